// File: doc/BRIEF.md
# APB GPIO Controller with Interrupt Detection

A memory-mapped general-purpose I/O block on an APB slave port, serving up to 32 pins. Software programs each pin's direction and drives its output through separate write-one set and clear registers, so several agents can change different pins without a read-modify-write race. Pin levels pass through a two-stage synchroniser and, per pin, an optional debounce filter before they are read back or watched for events.

Each pin can raise an interrupt. Three independent per-pin bits pick level or edge sensing, one or both edges, and rising/high or falling/low polarity. Edge events are latched until software clears them with a write-one-to-clear register. Level events track the pin directly. A raw status view, a masked status view and one combined interrupt line are provided; the interrupt line is meant to feed a parent interrupt controller outside this block.

Top module: `apb_gpio_irq`

## Requirements
- R1: After reset, every register reads zero, pin_o and pin_oe_o are all low and irq_o is low.
- R2: The direction register (offset 0x00) drives pin_oe_o bit for bit; a 1 makes the pin an output.
- R3: Writing the set register (offset 0x08) sets each output bit written as 1 and leaves bits written as 0 unchanged; pin_o and the output data register (offset 0x10) show the result.
- R4: Writing the clear register (offset 0x0C) clears each output bit written as 1 and leaves the others unchanged; outputs change only through these two registers.
- R5: The input data register (offset 0x14) returns the synchronised pin levels, one bit per pin.
- R6: With enable (0x18) set and sense (0x1C) at 0 and both-edges (0x20) at 0, a pin latches a raw status bit (0x28) on a rising edge when its polarity bit (0x24) is 1 and on a falling edge when it is 0.
- R7: In edge mode with the both-edges bit at 1, either edge latches the status bit regardless of polarity.
- R8: A latched edge status bit stays set until a 1 is written to that bit of the interrupt clear register (0x34); an edge arriving in the same cycle as the clear keeps the bit set.
- R9: With the sense bit at 1, raw status follows the pin level (active high when polarity is 1, active low when 0) and is not latched, so a clear write has no effect on it.
- R10: Masked status (0x30) equals raw status with every bit whose mask bit (0x2C) is 1 removed; irq_o is high exactly when any masked status bit is set.
- R11: A pin whose enable bit is 0 shows no raw status, whatever its input does.
- R12: With its debounce bit (0x38) set, a pin's value seen by the input register and the detector changes only after the synchronised input has differed for DB_CYCLES consecutive cycles (default 4); shorter glitches are dropped.
- R13: Offsets 0x04 and 0x3C and any unmapped offset read as zero and ignore writes; writes to the read-only input, raw and masked status registers have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always high |
| pin_i | input | N_PINS | Pin input levels (asynchronous) |
| pin_o | output | N_PINS | Pin output values |
| pin_oe_o | output | N_PINS | Pin output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The checker watches on every cycle that set and clear writes take effect on the following edge, that outputs hold steady between such writes, that latched edge status never drops without a clear write and that a detected edge always survives a simultaneous clear, and that a fully masked block keeps irq_o low. Edge and polarity selection, level tracking, enable gating, the debounce window and the behaviour of reserved and read-only offsets can only be shown by the bench's scenarios, which drive pin patterns and read the status registers back over APB.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [7:0] OFS_DIR   = 8'h00;
  localparam logic [7:0] OFS_CTRL  = 8'h04;
  localparam logic [7:0] OFS_SET   = 8'h08;
  localparam logic [7:0] OFS_CLR   = 8'h0C;
  localparam logic [7:0] OFS_ODATA = 8'h10;
  localparam logic [7:0] OFS_IDATA = 8'h14;
  localparam logic [7:0] OFS_IEN   = 8'h18;
  localparam logic [7:0] OFS_SENSE = 8'h1C;
  localparam logic [7:0] OFS_BOTH  = 8'h20;
  localparam logic [7:0] OFS_POL   = 8'h24;
  localparam logic [7:0] OFS_RAW   = 8'h28;
  localparam logic [7:0] OFS_MASK  = 8'h2C;
  localparam logic [7:0] OFS_MSTAT = 8'h30;
  localparam logic [7:0] OFS_ICLR  = 8'h34;
  localparam logic [7:0] OFS_DBEN  = 8'h38;
  localparam logic [7:0] OFS_CFG   = 8'h3C;

  localparam int unsigned DATA_W = 32;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int unsigned W      = 32,
  parameter int unsigned CYCLES = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned CW = $clog2(CYCLES) + 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [CW-1:0] cnt_q;
    logic          val_q;

    // val_q moves only after d_i has differed for CYCLES consecutive cycles
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        val_q <= 1'b0;
      end else if (d_i[i] == val_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q <= '0;
        val_q <= d_i[i];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    assign q_o[i] = val_q;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] ien_i,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] edge_hit_o,
  output logic [W-1:0] edge_st_o,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] prev_q, st_q;
  logic [W-1:0] rise, fall, edge_sel, lvl_act;

  always_comb begin
    rise     = in_i & ~prev_q;
    fall     = ~in_i & prev_q;
    edge_sel = (both_i & (rise | fall))
             | (~both_i & pol_i & rise)
             | (~both_i & ~pol_i & fall);
    lvl_act  = ien_i & sense_i & ~(in_i ^ pol_i);
  end

  assign edge_hit_o = ien_i & ~sense_i & edge_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      st_q   <= '0;
    end else begin
      prev_q <= in_i;
      // new edge has priority over a same-cycle clear
      st_q   <= (st_q & ~clr_i) | edge_hit_o;
    end
  end

  assign edge_st_o = st_q;
  assign raw_o     = lvl_act | (ien_i & ~sense_i & st_q);
endmodule

// File: rtl/apb_gpio_irq.sv
module apb_gpio_irq
  import gpio_pkg::*;
#(
  parameter int unsigned N_PINS    = 32,
  parameter int unsigned DB_CYCLES = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [ADDR_W-1:0]   paddr_i,
  input  logic [DATA_W-1:0]   pwdata_i,
  output logic [DATA_W-1:0]   prdata_o,
  output logic                pready_o,
  input  logic [N_PINS-1:0]   pin_i,
  output logic [N_PINS-1:0]   pin_o,
  output logic [N_PINS-1:0]   pin_oe_o,
  output logic                irq_o
);
  localparam int unsigned N = N_PINS;

  logic         wr_en;
  logic [N-1:0] wdat;
  logic [N-1:0] dir_q, out_q, ien_q, sense_q, both_q, pol_q, mask_q, dben_q;
  logic [N-1:0] sync_val, db_val, in_val;
  logic [N-1:0] iclr, edge_hit, edge_st, raw, mstat;

  assign wr_en    = psel_i & penable_i & pwrite_i;
  assign wdat     = pwdata_i[N-1:0];
  assign pready_o = 1'b1;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      out_q   <= '0;
      ien_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
      dben_q  <= '0;
    end else if (wr_en) begin
      if (hit(paddr_i, OFS_DIR))   dir_q   <= wdat;
      if (hit(paddr_i, OFS_SET))   out_q   <= out_q | wdat;
      if (hit(paddr_i, OFS_CLR))   out_q   <= out_q & ~wdat;
      if (hit(paddr_i, OFS_IEN))   ien_q   <= wdat;
      if (hit(paddr_i, OFS_SENSE)) sense_q <= wdat;
      if (hit(paddr_i, OFS_BOTH))  both_q  <= wdat;
      if (hit(paddr_i, OFS_POL))   pol_q   <= wdat;
      if (hit(paddr_i, OFS_MASK))  mask_q  <= wdat;
      if (hit(paddr_i, OFS_DBEN))  dben_q  <= wdat;
    end
  end

  assign iclr = (wr_en && hit(paddr_i, OFS_ICLR)) ? wdat : '0;

  gpio_sync #(.W(N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_val)
  );

  gpio_debounce #(.W(N), .CYCLES(DB_CYCLES)) u_db (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_val),
    .q_o   (db_val)
  );

  assign in_val = (dben_q & db_val) | (~dben_q & sync_val);

  gpio_irq_detect #(.W(N)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_i      (in_val),
    .ien_i     (ien_q),
    .sense_i   (sense_q),
    .both_i    (both_q),
    .pol_i     (pol_q),
    .clr_i     (iclr),
    .edge_hit_o(edge_hit),
    .edge_st_o (edge_st),
    .raw_o     (raw)
  );

  assign mstat    = raw & ~mask_q;
  assign irq_o    = |mstat;
  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;

  always_comb begin
    prdata_o = '0;
    unique case (1'b1)
      hit(paddr_i, OFS_DIR):   prdata_o = DATA_W'(dir_q);
      hit(paddr_i, OFS_ODATA): prdata_o = DATA_W'(out_q);
      hit(paddr_i, OFS_IDATA): prdata_o = DATA_W'(in_val);
      hit(paddr_i, OFS_IEN):   prdata_o = DATA_W'(ien_q);
      hit(paddr_i, OFS_SENSE): prdata_o = DATA_W'(sense_q);
      hit(paddr_i, OFS_BOTH):  prdata_o = DATA_W'(both_q);
      hit(paddr_i, OFS_POL):   prdata_o = DATA_W'(pol_q);
      hit(paddr_i, OFS_RAW):   prdata_o = DATA_W'(raw);
      hit(paddr_i, OFS_MASK):  prdata_o = DATA_W'(mask_q);
      hit(paddr_i, OFS_MSTAT): prdata_o = DATA_W'(mstat);
      hit(paddr_i, OFS_DBEN):  prdata_o = DATA_W'(dben_q);
      default:                 prdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_checker.sv
module gpio_checker #(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic [31:0]       pwdata_i,
  input logic [N-1:0]      out_q,
  input logic [N-1:0]      edge_hit,
  input logic [N-1:0]      edge_st,
  input logic [N-1:0]      mask_q,
  input logic              irq_o
);
  logic wr_set, wr_clr, wr_iclr;
  assign wr_set  = psel_i && penable_i && pwrite_i && paddr_i == ADDR_W'(8'h08);
  assign wr_clr  = psel_i && penable_i && pwrite_i && paddr_i == ADDR_W'(8'h0C);
  assign wr_iclr = psel_i && penable_i && pwrite_i && paddr_i == ADDR_W'(8'h34);

  a_r3_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((out_q & $past(pwdata_i[N-1:0])) == $past(pwdata_i[N-1:0])));

  a_r4_clear_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((out_q & $past(pwdata_i[N-1:0])) == '0));

  a_r4_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_set || wr_clr) |=> $stable(out_q));

  a_r8_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_hit) |=> ((edge_st & $past(edge_hit)) == $past(edge_hit)));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_iclr |=> ((edge_st & $past(edge_st)) == $past(edge_st)));

  a_r10_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o);
endmodule

bind apb_gpio_irq gpio_checker #(.N(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .psel_i   (psel_i),
  .penable_i(penable_i),
  .pwrite_i (pwrite_i),
  .paddr_i  (paddr_i),
  .pwdata_i (pwdata_i),
  .out_q    (out_q),
  .edge_hit (edge_hit),
  .edge_st  (edge_st),
  .mask_q   (mask_q),
  .irq_o    (irq_o)
);

// File: tb/apb_gpio_irq_bench.sv
`timescale 1ns/1ps
module apb_gpio_irq_bench;
  localparam int unsigned N = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0;
  logic [7:0]  paddr_i = '0;
  logic [31:0] pwdata_i = '0;
  logic [31:0] prdata_o;
  logic        pready_o;
  logic [N-1:0] pin_i = '0;
  logic [N-1:0] pin_o, pin_oe_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  apb_gpio_irq u_apb_gpio_irq (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i,
    .prdata_o, .pready_o, .pin_i, .pin_o, .pin_oe_o, .irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    psel_i = 1'b1; pwrite_i = 1'b1; paddr_i = a; pwdata_i = d; penable_i = 1'b0;
    @(negedge clk_i);
    penable_i = 1'b1;
    @(posedge clk_i);
    #1;
    psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    psel_i = 1'b1; pwrite_i = 1'b0; paddr_i = a; penable_i = 1'b0;
    @(negedge clk_i);
    penable_i = 1'b1;
    #1 d = prdata_o;
    @(posedge clk_i);
    #1;
    psel_i = 1'b0; penable_i = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic drive_pins(input logic [N-1:0] v);
    @(negedge clk_i);
    pin_i = v;
  endtask

  task automatic pulse_pin(input int bit_idx, input int len);
    @(negedge clk_i);
    pin_i[bit_idx] = 1'b1;
    repeat (len) @(negedge clk_i);
    pin_i[bit_idx] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 pin_o", pin_o, '0);
    chk("R1 pin_oe_o", pin_oe_o, '0);
    chk("R1 irq_o", {31'b0, irq_o}, 0);
    rd(8'h00, d); chk("R1 dir", d, 0);
    rd(8'h10, d); chk("R1 odata", d, 0);
    rd(8'h2C, d); chk("R1 mask", d, 0);
    rd(8'h28, d); chk("R1 raw", d, 0);
  endtask

  task automatic t_outputs;
    logic [31:0] d;
    wr(8'h00, 32'h0000_00FF);
    chk("R2 pin_oe_o", pin_oe_o, 32'h0000_00FF);
    wr(8'h08, 32'h0000_00A5);
    chk("R3 pin_o after set", pin_o, 32'h0000_00A5);
    wr(8'h08, 32'h0000_000F);
    chk("R3 set keeps zeros", pin_o, 32'h0000_00AF);
    wr(8'h0C, 32'h0000_0081);
    chk("R4 pin_o after clear", pin_o, 32'h0000_002E);
    rd(8'h10, d); chk("R3 odata readback", d, 32'h0000_002E);
  endtask

  task automatic t_input;
    logic [31:0] d;
    drive_pins(32'h1234_5678);
    cyc(3);
    rd(8'h14, d); chk("R5 idata", d, 32'h1234_5678);
    drive_pins('0);
    cyc(3);
    rd(8'h14, d); chk("R5 idata zero", d, 0);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    drive_pins(32'h2);
    cyc(4);
    wr(8'h1C, 0);
    wr(8'h20, 32'h4);
    wr(8'h24, 32'h1);
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h18, 32'h7);
    drive_pins(32'h3); cyc(5);
    rd(8'h28, d); chk("R6 rising edge pin0", d, 32'h1);
    chk("R10 irq_o on raw", {31'b0, irq_o}, 1);
    drive_pins(32'h1); cyc(5);
    rd(8'h28, d); chk("R6 falling edge pin1", d, 32'h3);
    drive_pins(32'h5); cyc(5);
    rd(8'h28, d); chk("R7 both-edges rise pin2", d, 32'h7);
    wr(8'h34, 32'h4);
    rd(8'h28, d); chk("R8 clear single bit", d, 32'h3);
    drive_pins(32'h1); cyc(5);
    rd(8'h28, d); chk("R7 both-edges fall pin2", d, 32'h7);
    drive_pins(32'h0); cyc(5);
    rd(8'h28, d); chk("R8 sticky, R6 wrong edge ignored", d, 32'h7);
    wr(8'h34, 32'h7);
    rd(8'h28, d); chk("R8 clear all", d, 0);
    chk("R10 irq_o low", {31'b0, irq_o}, 0);
    drive_pins(32'h8); cyc(5);
    rd(8'h28, d); chk("R11 disabled pin3", d, 0);
    chk("R11 irq_o stays low", {31'b0, irq_o}, 0);
    drive_pins(32'h0); cyc(4);
  endtask

  task automatic t_level_mask;
    logic [31:0] d;
    wr(8'h18, 0);
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h1C, 32'h30);
    wr(8'h20, 0);
    wr(8'h24, 32'h10);
    wr(8'h18, 32'h30);
    rd(8'h28, d); chk("R9 active-low pin5", d, 32'h20);
    drive_pins(32'h30); cyc(4);
    rd(8'h28, d); chk("R9 active-high pin4", d, 32'h10);
    wr(8'h34, 32'h10);
    rd(8'h28, d); chk("R9 clear has no effect", d, 32'h10);
    wr(8'h2C, 32'h10);
    rd(8'h30, d); chk("R10 masked status", d, 0);
    chk("R10 irq_o masked", {31'b0, irq_o}, 0);
    rd(8'h28, d); chk("R10 raw unaffected by mask", d, 32'h10);
    wr(8'h2C, 0);
    rd(8'h30, d); chk("R10 unmasked status", d, 32'h10);
    chk("R10 irq_o unmasked", {31'b0, irq_o}, 1);
    drive_pins(32'h20); cyc(4);
    rd(8'h28, d); chk("R9 level inactive", d, 0);
    chk("R9 irq_o drops", {31'b0, irq_o}, 0);
    drive_pins(32'h0); cyc(4);
  endtask

  task automatic t_debounce;
    logic [31:0] d;
    wr(8'h18, 0);
    wr(8'h1C, 0);
    wr(8'h24, 32'h100);
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h18, 32'h100);
    pulse_pin(8, 2); cyc(5);
    rd(8'h28, d); chk("R12 glitch seen unfiltered", d, 32'h100);
    wr(8'h34, 32'h100);
    wr(8'h38, 32'h100);
    pulse_pin(8, 2); cyc(8);
    rd(8'h28, d); chk("R12 glitch dropped", d, 0);
    rd(8'h14, d); chk("R12 idata after glitch", d, 0);
    drive_pins(32'h100); cyc(3);
    rd(8'h14, d); chk("R12 not yet stable", d, 0);
    cyc(10);
    rd(8'h14, d); chk("R12 stable passes", d, 32'h100);
    rd(8'h28, d); chk("R12 edge after filter", d, 32'h100);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R13 offset 0x04", d, 0);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h3C, d); chk("R13 offset 0x3C", d, 0);
    rd(8'h40, d); chk("R13 unmapped", d, 0);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, d); chk("R13 raw write ignored", d, 32'h100);
    wr(8'h14, 32'h0000_FFFF);
    rd(8'h14, d); chk("R13 idata write ignored", d, 32'h100);
    rd(8'h10, d); chk("R13 odata unchanged", d, 32'h0000_002E);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    @(negedge clk_i) rst_ni = 1'b1;
    cyc(2);
    t_reset;
    t_outputs;
    t_input;
    t_edges;
    t_level_mask;
    t_debounce;
    t_reserved;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule